// File: doc/BRIEF.md
# Jitter attenuator elastic store

This block absorbs timing jitter between a bursty or gapped bit stream and a smooth output stream. Incoming bits are written into a 64-bit elastic store whenever the write side presents one. A phase accumulator produces an evenly spaced read strobe and stands in for a narrow-band PLL. The accumulator's increment is steered slowly by the store's fill level around its midpoint. Inside guard bands near empty or full it is steered hard, so the store neither loses nor repeats a bit. At the hard limits the read behaviour changes outright. A write into a full store forces a read in the same cycle. A read strobe that finds the store empty is withheld.

A two-bit location control places the store in the receive path or the transmit path, or bypasses it so that input bits pass straight to the output. On loss of signal the behaviour depends on the path. In the receive path the last steered read rate is held. Elsewhere the read rate returns to the nominal reference rate. After reset the store is treated as not yet locked and uses wide guard bands. Once the fill level has stayed between them for a set time, it narrows the guard bands so that more wander is tolerated.

Top module: `att_jitter_store`

## Requirements
- R1: After reset the fill level is 32, the read increment is the nominal 1024 (of a 4096 accumulator modulus), `locked` is 0 and `rd_valid` is 0; the 32 preset bits read out as 0.
- R2: `loc_sel` decodes as 2'b00 receive path (`path_rx`=1), 2'b01 transmit path (`path_tx`=1), 2'b10 bypass, and 2'b11 also bypass (both path outputs 0).
- R3: The fill level never exceeds 64; a write arriving while the store holds 64 bits forces a read in the same cycle, so the fill level stays at 64 and one bit leaves for every bit written.
- R4: A read strobe that finds the store empty produces no `rd_valid`, and the fill level never drops below 0.
- R5: Every bit written while the store is in a path leaves it in write order, after the 32 preset bits, with none lost or repeated.
- R6: A read is issued on each carry out of the 12-bit phase accumulator; at the nominal increment, with the fill level at its midpoint, two successive reads are 4 cycles apart.
- R7: On a read strobe outside the guard bands, the increment changes by at most 1: up when the fill level is above 32, down when it is below.
- R8: On a read strobe inside a guard band, the increment moves by 32: down near empty, up near full. It is always kept within 512..2048.
- R9: While unlocked, the guard bands are fill levels below 21 and above 43. While locked, they are below 10 and above 54. The store locks after 200 consecutive in-path cycles outside a guard band without loss of signal. Entering a guard band clears the lock.
- R10: With the receive path selected and `los` high, the increment holds its value.
- R11: With `los` high and the receive path not selected, the increment becomes the nominal 1024.
- R12: In bypass, `rd_valid`/`rd_data` follow `wr_valid`/`wr_data` in the same cycle and the fill level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_sel | input | 2 | Location of the store: receive, transmit or bypass |
| los | input | 1 | Loss of signal |
| wr_valid | input | 1 | A bit is offered on `wr_data` this cycle |
| wr_data | input | 1 | Incoming bit |
| rd_valid | output | 1 | A bit is presented on `rd_data` this cycle |
| rd_data | output | 1 | Outgoing bit |
| fill | output | 7 | Bits currently held, 0..64 |
| rate_inc | output | 12 | Current phase accumulator increment |
| locked | output | 1 | Narrow guard bands in use |
| path_rx | output | 1 | Store is in the receive path |
| path_tx | output | 1 | Store is in the transmit path |

## Verification
The bench drives the store continuously full and continuously starved. A design that drops or duplicates a bit at either limit breaks the bench's bit-order model. A design that lets a strobe through on an empty store shows `rd_valid` with no bit to give. The same 24-bit burst is sent twice, once after lock with the fill level near 50 and once before lock. Only the unlocked run may apply a 32-step correction, which exposes swapped or mis-sized guard bands. The bench also drains the store under loss of signal, where a design without holdover would ramp the increment down. It checks the bypass and reserved codes for a same-cycle pass-through with a frozen fill level.

// File: rtl/att_pkg.sv
package att_pkg;

    typedef enum logic [1:0] {
        LOC_RX   = 2'b00,
        LOC_TX   = 2'b01,
        LOC_NONE = 2'b10,
        LOC_RSVD = 2'b11
    } loc_e;

    typedef struct packed {
        logic rx;
        logic tx;
    } path_t;

    typedef enum logic [2:0] {
        ZN_MID,
        ZN_ABOVE,
        ZN_BELOW,
        ZN_GUARD_LO,
        ZN_GUARD_HI
    } zone_e;

    function automatic path_t decode_loc(input logic [1:0] code);
        path_t p;
        p = '0;
        case (loc_e'(code))
            LOC_RX:  p.rx = 1'b1;
            LOC_TX:  p.tx = 1'b1;
            default: p = '0;
        endcase
        return p;
    endfunction

    function automatic zone_e classify(input int unsigned level,
                                       input int unsigned guard,
                                       input int unsigned depth);
        if (level < guard)              return ZN_GUARD_LO;
        else if (level > depth - guard) return ZN_GUARD_HI;
        else if (level > depth / 2)     return ZN_ABOVE;
        else if (level < depth / 2)     return ZN_BELOW;
        else                            return ZN_MID;
    endfunction

endpackage

// File: rtl/att_elastic_fifo.sv
module att_elastic_fifo #(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    input  logic                         wr_valid,
    input  logic                         wr_data,
    input  logic                         rd_tick,
    output logic                         rd_valid_o,
    output logic                         rd_data_o,
    output logic [$clog2(DEPTH+1)-1:0]   fill_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int FW = $clog2(DEPTH + 1);
    localparam logic [FW-1:0] FULL_LVL = FW'(DEPTH);
    localparam logic [FW-1:0] HALF_LVL = FW'(DEPTH / 2);

    logic [DEPTH-1:0] mem_q;
    logic [PW-1:0]    wptr_q, rptr_q;
    logic [FW-1:0]    fill_q, fill_n;
    logic             wr_do, rd_req, rd_do, full, empty;

    always_comb begin
        full   = (fill_q == FULL_LVL);
        empty  = (fill_q == '0);
        wr_do  = en & wr_valid;
        // a write into a full store pulls a bit out in the same cycle
        rd_req = en & (rd_tick | (full & wr_do));
        rd_do  = rd_req & ~empty;
        fill_n = fill_q + FW'(wr_do) - FW'(rd_do);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q      <= '0;
            wptr_q     <= PW'(DEPTH / 2);
            rptr_q     <= '0;
            fill_q     <= HALF_LVL;
            rd_valid_o <= 1'b0;
            rd_data_o  <= 1'b0;
        end else begin
            if (wr_do) begin
                mem_q[wptr_q] <= wr_data;
                wptr_q        <= wptr_q + 1'b1;
            end
            if (rd_do) begin
                rd_data_o <= mem_q[rptr_q];
                rptr_q    <= rptr_q + 1'b1;
            end
            rd_valid_o <= rd_do;
            fill_q     <= fill_n;
        end
    end

    assign fill_o = fill_q;

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (fill_o == FULL_LVL && en && wr_valid) |=> (fill_o == FULL_LVL && rd_valid_o));

    a_r3_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill_o <= FULL_LVL);

    a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (fill_o == '0 && !(en && wr_valid)) |=> (fill_o == '0 && !rd_valid_o));

endmodule

// File: rtl/att_rate_ctrl.sv
module att_rate_ctrl
    import att_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int ACC_W       = 12,
    parameter int NOM_INC     = 1024,
    parameter int FINE_STEP   = 1,
    parameter int COARSE_STEP = 32,
    parameter int INC_MIN     = 512,
    parameter int INC_MAX     = 2048,
    parameter int GUARD_UNLK  = 21,
    parameter int GUARD_LCK   = 10,
    parameter int LOCK_CYC    = 200
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic                       los,
    input  logic                       rx_path,
    input  logic [$clog2(DEPTH+1)-1:0] fill_i,
    output logic                       tick_o,
    output logic [ACC_W-1:0]           inc_o,
    output logic                       locked_o
);
    localparam int CW = $clog2(LOCK_CYC + 1);
    localparam int SW = ACC_W + 2;
    localparam logic [ACC_W-1:0] NOM_V = ACC_W'(NOM_INC);
    localparam logic [ACC_W-1:0] MIN_V = ACC_W'(INC_MIN);
    localparam logic [ACC_W-1:0] MAX_V = ACC_W'(INC_MAX);

    logic [ACC_W-1:0]        acc_q, inc_q, inc_next;
    logic [ACC_W:0]          sum;
    logic [CW-1:0]           lock_cnt_q;
    logic                    locked_q, in_guard;
    zone_e                   zone;
    logic signed [SW-1:0]    delta, stepped;

    always_comb begin
        sum      = {1'b0, acc_q} + {1'b0, inc_q};
        tick_o   = en & sum[ACC_W];
        zone     = classify(32'(fill_i),
                            locked_q ? 32'(GUARD_LCK) : 32'(GUARD_UNLK),
                            32'(DEPTH));
        in_guard = (zone == ZN_GUARD_LO) || (zone == ZN_GUARD_HI);
        case (zone)
            ZN_GUARD_LO: delta = -$signed(SW'(COARSE_STEP));
            ZN_GUARD_HI: delta =  $signed(SW'(COARSE_STEP));
            ZN_ABOVE:    delta =  $signed(SW'(FINE_STEP));
            ZN_BELOW:    delta = -$signed(SW'(FINE_STEP));
            default:     delta = '0;
        endcase
        stepped = $signed({2'b00, inc_q}) + delta;
        if (stepped < $signed(SW'(INC_MIN)))      inc_next = MIN_V;
        else if (stepped > $signed(SW'(INC_MAX))) inc_next = MAX_V;
        else                                      inc_next = stepped[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= '0;
            inc_q      <= NOM_V;
            lock_cnt_q <= '0;
            locked_q   <= 1'b0;
        end else begin
            if (en) acc_q <= sum[ACC_W-1:0];

            if (los && !rx_path)          inc_q <= NOM_V;
            else if (!los && tick_o)      inc_q <= inc_next;

            if (en && !los) begin
                if (in_guard) begin
                    lock_cnt_q <= '0;
                    locked_q   <= 1'b0;
                end else if (!locked_q) begin
                    if (lock_cnt_q == CW'(LOCK_CYC - 1)) locked_q <= 1'b1;
                    else                                 lock_cnt_q <= lock_cnt_q + 1'b1;
                end
            end
        end
    end

    assign inc_o    = inc_q;
    assign locked_o = locked_q;

    a_r10_holdover: assert property (@(posedge clk) disable iff (rst)
        (los && rx_path) |=> (inc_o == $past(inc_o)));

    a_r11_ref_rate: assert property (@(posedge clk) disable iff (rst)
        (los && !rx_path) |=> (inc_o == NOM_V));

    a_r8_inc_bounds: assert property (@(posedge clk) disable iff (rst)
        (inc_o >= MIN_V) && (inc_o <= MAX_V));

    a_r7_fine_step: assert property (@(posedge clk) disable iff (rst)
        (en && !los && tick_o && !in_guard) |=>
        ((inc_o <= $past(inc_o) + ACC_W'(FINE_STEP)) &&
         (inc_o + ACC_W'(FINE_STEP) >= $past(inc_o))));

    a_r8_coarse_up: assert property (@(posedge clk) disable iff (rst)
        (en && !los && tick_o && zone == ZN_GUARD_HI &&
         inc_o <= MAX_V - ACC_W'(COARSE_STEP)) |=>
        (inc_o == $past(inc_o) + ACC_W'(COARSE_STEP)));

    a_r9_guard_unlocks: assert property (@(posedge clk) disable iff (rst)
        (en && !los && in_guard) |=> !locked_o);

endmodule

// File: rtl/att_jitter_store.sv
module att_jitter_store
    import att_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int ACC_W       = 12,
    parameter int NOM_INC     = 1024,
    parameter int FINE_STEP   = 1,
    parameter int COARSE_STEP = 32,
    parameter int INC_MIN     = 512,
    parameter int INC_MAX     = 2048,
    parameter int GUARD_UNLK  = 21,
    parameter int GUARD_LCK   = 10,
    parameter int LOCK_CYC    = 200
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [1:0]                 loc_sel,
    input  logic                       los,
    input  logic                       wr_valid,
    input  logic                       wr_data,
    output logic                       rd_valid,
    output logic                       rd_data,
    output logic [$clog2(DEPTH+1)-1:0] fill,
    output logic [ACC_W-1:0]           rate_inc,
    output logic                       locked,
    output logic                       path_rx,
    output logic                       path_tx
);
    localparam int FW = $clog2(DEPTH + 1);

    path_t          path;
    logic           active, tick, f_valid, f_data;
    logic [FW-1:0]  f_fill;

    always_comb begin
        path   = decode_loc(loc_sel);
        active = path.rx | path.tx;
    end

    att_elastic_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .en         (active),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .rd_tick    (tick),
        .rd_valid_o (f_valid),
        .rd_data_o  (f_data),
        .fill_o     (f_fill)
    );

    att_rate_ctrl #(
        .DEPTH       (DEPTH),
        .ACC_W       (ACC_W),
        .NOM_INC     (NOM_INC),
        .FINE_STEP   (FINE_STEP),
        .COARSE_STEP (COARSE_STEP),
        .INC_MIN     (INC_MIN),
        .INC_MAX     (INC_MAX),
        .GUARD_UNLK  (GUARD_UNLK),
        .GUARD_LCK   (GUARD_LCK),
        .LOCK_CYC    (LOCK_CYC)
    ) u_rate (
        .clk      (clk),
        .rst      (rst),
        .en       (active),
        .los      (los),
        .rx_path  (path.rx),
        .fill_i   (f_fill),
        .tick_o   (tick),
        .inc_o    (rate_inc),
        .locked_o (locked)
    );

    // bypass hands the input straight through with no register
    assign rd_valid = active ? f_valid : wr_valid;
    assign rd_data  = active ? f_data  : wr_data;
    assign fill     = f_fill;
    assign path_rx  = path.rx;
    assign path_tx  = path.tx;

    a_r12_bypass_frozen: assert property (@(posedge clk) disable iff (rst)
        !active |=> $stable(fill));

endmodule

// File: tb/test_att_jitter_store.sv
module test_att_jitter_store;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  loc_sel = 2'b00;
    logic        los = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_data = 1'b0;
    logic        rd_valid, rd_data, locked, path_rx, path_tx;
    logic [6:0]  fill;
    logic [11:0] rate_inc;

    att_jitter_store i_att_jitter_store (
        .clk(clk), .rst(rst), .loc_sel(loc_sel), .los(los),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .fill(fill),
        .rate_inc(rate_inc), .locked(locked),
        .path_rx(path_rx), .path_tx(path_tx)
    );

    always #(CLK_NS/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    bit model[$];
    int model_err, rd_count, cyc, first_rd, second_rd;
    int prev_inc, pat;
    bit saw_fine, saw_big, saw_up32, saw_dn32;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_flags();
        saw_fine = 0; saw_big = 0; saw_up32 = 0; saw_dn32 = 0;
    endtask

    // output monitor: bit-order model and increment step watcher
    always @(negedge clk) begin
        if (rst) begin
            prev_inc = int'(rate_inc);
        end else begin
            int d;
            cyc++;
            if ((path_rx || path_tx) && rd_valid) begin
                rd_count++;
                if (first_rd < 0) first_rd = cyc;
                else if (second_rd < 0) second_rd = cyc;
                if (model.size() == 0) model_err++;
                else begin
                    bit e;
                    e = model.pop_front();
                    if (e !== rd_data) model_err++;
                end
            end
            d = int'(rate_inc) - prev_inc;
            if (d == 1 || d == -1) saw_fine = 1;
            if (d > 1 || d < -1)   saw_big  = 1;
            if (d == 32)           saw_up32 = 1;
            if (d == -32)          saw_dn32 = 1;
            prev_inc = int'(rate_inc);
        end
    end

    task automatic do_reset(input logic [1:0] loc);
        @(negedge clk); #1;
        rst = 1; loc_sel = loc; los = 0; wr_valid = 0; wr_data = 0;
        repeat (3) @(negedge clk);
        #1;
        model.delete();
        for (int i = 0; i < 32; i++) model.push_back(1'b0);
        model_err = 0; rd_count = 0; cyc = 0; first_rd = -1; second_rd = -1;
        clear_flags();
        rst = 0;
    endtask

    task automatic drive(input bit v);
        bit b;
        pat++;
        b = pat[0] ^ pat[2] ^ pat[3];
        @(negedge clk); #1;
        wr_valid = v; wr_data = b;
        if (v && loc_sel[1] == 1'b0) model.push_back(b);
    endtask

    task automatic quarter_rate(input int cycles);
        for (int i = 0; i < cycles; i++) drive(i % 4 == 0);
    endtask

    task automatic t_reset();
        do_reset(2'b00);
        check(fill == 7'd32, "R1 fill", fill, 32);
        check(rate_inc == 12'd1024, "R1 rate_inc", rate_inc, 1024);
        check(locked == 1'b0, "R1 locked", locked, 0);
        check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        check(path_rx && !path_tx, "R2 code 00", {path_rx, path_tx}, 2);
        repeat (20) drive(0);
        check(second_rd - first_rd == 4, "R6 read spacing", second_rd - first_rd, 4);
        check(model_err == 0, "R5 preset bits", model_err, 0);
    endtask

    task automatic t_decode_bypass();
        int bad;
        logic [6:0] f0;
        do_reset(2'b01);
        check(!path_rx && path_tx, "R2 code 01", {path_rx, path_tx}, 1);
        for (int c = 2; c < 4; c++) begin
            do_reset(c[1:0]);
            check(!path_rx && !path_tx, "R2 bypass code", {path_rx, path_tx}, 0);
            f0 = fill;
            bad = 0;
            for (int i = 0; i < 16; i++) begin
                drive(i % 3 != 0);
                #1;
                if (rd_valid !== wr_valid || rd_data !== wr_data) bad++;
            end
            check(bad == 0, "R12 pass-through", bad, 0);
            check(fill == f0, "R12 fill frozen", fill, f0);
        end
    endtask

    task automatic t_locked_burst();
        do_reset(2'b00);
        quarter_rate(480);
        check(!saw_big && saw_fine, "R7 fine steps only", int'(saw_big), 0);
        check(locked == 1'b1, "R9 locks", locked, 1);
        clear_flags();
        repeat (24) drive(1);
        drive(0);
        check(fill > 7'd43 && fill <= 7'd54, "R9 burst level", fill, 50);
        check(locked == 1'b1, "R9 wide tolerance", locked, 1);
        check(!saw_up32, "R9 no coarse when locked", int'(saw_up32), 0);
        check(model_err == 0, "R5 order locked", model_err, 0);
    endtask

    task automatic t_unlocked_burst();
        do_reset(2'b00);
        quarter_rate(40);
        clear_flags();
        repeat (24) drive(1);
        drive(0);
        check(fill > 7'd43, "R9 burst level unlocked", fill, 50);
        check(saw_up32, "R8 coarse up in guard", int'(saw_up32), 1);
        check(locked == 1'b0, "R9 unlocked", locked, 0);
    endtask

    task automatic t_overflow();
        int c0;
        do_reset(2'b01);
        repeat (1500) drive(1);
        c0 = rd_count;
        repeat (40) drive(1);
        check(fill == 7'd64, "R3 full level", fill, 64);
        check(rd_count - c0 == 40, "R3 forced reads", rd_count - c0, 40);
        check(rate_inc == 12'd2048, "R8 upper clamp", rate_inc, 2048);
        check(model_err == 0, "R5 order at full", model_err, 0);
    endtask

    task automatic t_starve();
        int c0;
        do_reset(2'b00);
        repeat (1500) drive(0);
        c0 = rd_count;
        repeat (100) drive(0);
        check(fill == 7'd0, "R4 empty level", fill, 0);
        check(rd_count == c0, "R4 no read when empty", rd_count - c0, 0);
        check(saw_dn32, "R8 coarse down in guard", int'(saw_dn32), 1);
        check(rate_inc == 12'd512, "R8 lower clamp", rate_inc, 512);
        check(model_err == 0 && model.size() == 0, "R5 all bits out", model_err + model.size(), 0);
        @(negedge clk); #1; loc_sel = 2'b01; los = 1;
        repeat (3) drive(0);
        check(rate_inc == 12'd1024, "R11 reference rate tx", rate_inc, 1024);
        @(negedge clk); #1; loc_sel = 2'b10;
        repeat (3) drive(0);
        check(rate_inc == 12'd1024, "R11 reference rate bypass", rate_inc, 1024);
    endtask

    task automatic t_holdover();
        int snap;
        do_reset(2'b00);
        quarter_rate(100);
        @(negedge clk); #1; los = 1; wr_valid = 0;
        @(negedge clk);
        snap = int'(rate_inc);
        repeat (400) drive(0);
        check(int'(rate_inc) == snap, "R10 holdover", rate_inc, snap);
        check(fill == 7'd0, "R4 drained under holdover", fill, 0);
        check(model_err == 0, "R5 order under holdover", model_err, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        pat = 0;
        t_reset();
        t_decode_bypass();
        t_locked_burst();
        t_unlocked_burst();
        t_overflow();
        t_starve();
        t_holdover();
        done = 1;
        finish_run();
    end

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule